// File: doc/BRIEF.md
# RFID Reader Empty-Slot Timeout Timer

This block watches each reader-to-tag exchange and decides when a time slot is empty. When the transmitter finishes a frame, the block starts counting in fixed steps. A step is one prescaler period, which is 512 clocks of the 13.56 MHz carrier-derived clock, or about 37.76 µs. If no tag reply has started when the programmed number of steps has passed, the block raises a one-cycle interrupt request and sets a sticky no-response flag. Firmware therefore does not need to time empty slots itself.

The step count is an 8-bit wait value. Software can write it directly. It is also replaced by a preset every time a protocol is selected: about 529 µs for general protocols, 755 µs for fast vicinity cards and 1812 µs for slow vicinity cards. A tag reply that starts in time stops the count. So does a FIFO-reset command issued after transmission ended. A new end-of-frame pulse restarts the full window.

Top module: `nrt_noresp_timer`

## Requirements
- R1: After reset, `wait_value` is 14, `irq` is 0 and `noresp_flag` is 0.
- R2: A write on `wait_wr` stores `wait_wdata`, except that the value 0 is stored as 1. `wait_value` is therefore never 0.
- R3: A `proto_wr` strobe loads a preset selected by `proto_code`: 2'b00 gives 14, 2'b01 (fast vicinity) gives 20, 2'b10 (slow vicinity) gives 48 and 2'b11 gives 14. If `proto_wr` and `wait_wr` are asserted in the same cycle, the preset wins.
- R4: Take a `tx_eof` pulse sampled at clock edge E, with wait value W held at that edge. With no later event, `irq` is high for exactly the one cycle that follows edge E + W·PRESCALE_DIV. Changing the register after edge E does not alter that exchange.
- R5: `noresp_flag` sets on the same edge as `irq`. It stays set until a `flag_clr` pulse. If a set and a clear fall on the same edge, the set wins.
- R6: An `rx_start` pulse while the timer is running stops it and no `irq` follows. This also holds when the pulse falls on the expiry edge itself.
- R7: A `fifo_reset` pulse while the timer is running stops it and no `irq` follows. While the timer is idle, `fifo_reset` has no effect.
- R8: A `tx_eof` pulse while the timer is running restarts the whole window from the current wait value. This also holds on the expiry edge, where it suppresses that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or chip disable) |
| wait_wr | input | 1 | Write strobe for the wait value |
| wait_wdata | input | 8 | Wait value in prescaler steps |
| proto_wr | input | 1 | Protocol-selection write strobe |
| proto_code | input | 2 | Selected protocol class |
| tx_eof | input | 1 | Single-cycle pulse at the end of the transmitted frame |
| rx_start | input | 1 | Single-cycle pulse when a tag reply begins |
| fifo_reset | input | 1 | FIFO-reset command strobe |
| flag_clr | input | 1 | Clears the no-response flag |
| irq | output | 1 | One-cycle interrupt request on timeout |
| noresp_flag | output | 1 | Sticky no-response status |
| wait_value | output | 8 | Current wait register contents |

## Verification
The assertions check the following on every clock: the single-cycle shape of `irq`, its coupling to the flag, that the flag holds until cleared, that the register is never zero, the preset loaded after each protocol strobe, and that reply, FIFO-reset and end-of-frame pulses all leave the next cycle free of an interrupt. Only the bench scenarios can show the exact edge on which the timeout fires for each wait value and protocol preset. The same goes for the length of a restarted window, the race of a reply or a clear against the expiry edge, and the fact that a later register write leaves a running exchange untouched.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
  localparam int unsigned WAIT_W = 8;
  typedef logic [WAIT_W-1:0] wait_t;

  typedef enum logic [1:0] {
    PROTO_GENERAL  = 2'b00,
    PROTO_VIC_FAST = 2'b01,
    PROTO_VIC_SLOW = 2'b10,
    PROTO_GEN_ALT  = 2'b11
  } proto_e;

  localparam wait_t RESET_WAIT = wait_t'(14);

  // Step count preset for a protocol class
  function automatic wait_t preset_for(proto_e p);
    case (p)
      PROTO_VIC_FAST: return wait_t'(20);
      PROTO_VIC_SLOW: return wait_t'(48);
      default:        return wait_t'(14);
    endcase
  endfunction

  // A zero-length window is not allowed: 0 becomes 1
  function automatic wait_t sanitize(wait_t v);
    return (v == '0) ? wait_t'(1) : v;
  endfunction
endpackage

// File: rtl/nrt_prescaler.sv
module nrt_prescaler #(
  parameter int unsigned DIV = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_q <= '0;
    else if (restart)      pre_q <= '0;
    else if (!run)         pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + PW'(1);
  end

  assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/nrt_wait_reg.sv
module nrt_wait_reg
  import nrt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  wait_t wr_data,
  input  logic  proto_wr,
  input  logic [1:0] proto_code,
  output wait_t value
);
  wait_t value_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        value_q <= RESET_WAIT;
    else if (proto_wr) value_q <= preset_for(proto_e'(proto_code));
    else if (wr_en)    value_q <= sanitize(wr_data);
  end

  assign value = value_q;
endmodule

// File: rtl/nrt_slot_counter.sv
module nrt_slot_counter
  import nrt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eof,
  input  logic  rx_start,
  input  logic  fifo_rst,
  input  logic  tick,
  input  wait_t load_value,
  output logic  armed,
  output logic  expire
);
  logic  armed_q;
  wait_t count_q;
  logic  stop_req;

  assign stop_req = rx_start || fifo_rst;
  assign expire   = armed_q && tick && (count_q == wait_t'(1)) && !stop_req && !eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      count_q <= '0;
    end else if (eof) begin
      armed_q <= 1'b1;
      count_q <= load_value;
    end else if (armed_q && stop_req) begin
      armed_q <= 1'b0;
    end else if (expire) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick) begin
      count_q <= count_q - wait_t'(1);
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/nrt_status.sv
module nrt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic irq,
  output logic flag
);
  logic irq_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= expire;
      if (expire)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign irq  = irq_q;
  assign flag = flag_q;
endmodule

// File: rtl/nrt_noresp_timer.sv
module nrt_noresp_timer
  import nrt_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_wr,
  input  logic [7:0] wait_wdata,
  input  logic       proto_wr,
  input  logic [1:0] proto_code,
  input  logic       tx_eof,
  input  logic       rx_start,
  input  logic       fifo_reset,
  input  logic       flag_clr,
  output logic       irq,
  output logic       noresp_flag,
  output logic [7:0] wait_value
);
  // Named internal events, visible to the bound checker
  logic  tick;
  logic  armed;
  logic  expire;
  wait_t reg_value;

  nrt_wait_reg u_wait_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wait_wr),
    .wr_data   (wait_wdata),
    .proto_wr  (proto_wr),
    .proto_code(proto_code),
    .value     (reg_value)
  );

  nrt_prescaler #(.DIV(PRESCALE_DIV)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(tx_eof),
    .run    (armed),
    .tick   (tick)
  );

  nrt_slot_counter u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .eof       (tx_eof),
    .rx_start  (rx_start),
    .fifo_rst  (fifo_reset),
    .tick      (tick),
    .load_value(reg_value),
    .armed     (armed),
    .expire    (expire)
  );

  nrt_status u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .expire(expire),
    .clr  (flag_clr),
    .irq  (irq),
    .flag (noresp_flag)
  );

  assign wait_value = reg_value;
endmodule

// File: rtl/nrt_noresp_checker.sv
module nrt_noresp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       proto_wr,
  input logic [1:0] proto_code,
  input logic       tx_eof,
  input logic       rx_start,
  input logic       fifo_reset,
  input logic       flag_clr,
  input logic       irq,
  input logic       noresp_flag,
  input logic [7:0] wait_value,
  input logic       tick,
  input logic       armed,
  input logic       expire
);
  function automatic logic [7:0] table_value(logic [1:0] c);
    if (c == 2'b01) return 8'd20;
    if (c == 2'b10) return 8'd48;
    return 8'd14;
  endfunction

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_tick_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> armed);
  assert_expire_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq && !armed);
  assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> noresp_flag);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    noresp_flag && !flag_clr |=> noresp_flag);
  assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noresp_flag) |-> irq);
  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_value != 8'd0);
  assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    proto_wr |=> wait_value == table_value($past(proto_code)));
  assert_rx_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rx_start && !tx_eof |=> !armed && !irq);
  assert_fifo_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && fifo_reset && !tx_eof |=> !armed && !irq);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq);
  assert_eof_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |=> armed && !irq);
endmodule

bind nrt_noresp_timer nrt_noresp_checker u_nrt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proto_wr   (proto_wr),
  .proto_code (proto_code),
  .tx_eof     (tx_eof),
  .rx_start   (rx_start),
  .fifo_reset (fifo_reset),
  .flag_clr   (flag_clr),
  .irq        (irq),
  .noresp_flag(noresp_flag),
  .wait_value (wait_value),
  .tick       (tick),
  .armed      (armed),
  .expire     (expire)
);

// File: tb/test_nrt_noresp_timer.sv
module test_nrt_noresp_timer;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wait_wr = 1'b0;
  logic [7:0] wait_wdata = '0;
  logic       proto_wr = 1'b0;
  logic [1:0] proto_code = '0;
  logic       tx_eof = 1'b0;
  logic       rx_start = 1'b0;
  logic       fifo_reset = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq;
  logic       noresp_flag;
  logic [7:0] wait_value;

  int errors = 0;
  int checks = 0;
  int edge_cnt = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  nrt_noresp_timer #(.PRESCALE_DIV(DIV)) i_nrt_noresp_timer (
    .clk(clk), .rst_n(rst_n), .wait_wr(wait_wr), .wait_wdata(wait_wdata),
    .proto_wr(proto_wr), .proto_code(proto_code), .tx_eof(tx_eof),
    .rx_start(rx_start), .fifo_reset(fifo_reset), .flag_clr(flag_clr),
    .irq(irq), .noresp_flag(noresp_flag), .wait_value(wait_value)
  );

  function automatic int eff_wait(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int preset_of(int code);
    case (code)
      1:       return 20;
      2:       return 48;
      default: return 14;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: compares irq events against the scoreboard queue
  always @(posedge clk) begin
    #1;
    edge_cnt++;
    if (rst_n) begin
      if (exp_q.size() > 0 && edge_cnt > exp_q[0]) begin
        check(1'b0, "R4 missed irq", edge_cnt, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (irq) begin
        if (exp_q.size() == 0) check(1'b0, "R4/R6/R7/R8 unexpected irq", edge_cnt, -1);
        else check(exp_q.pop_front() == edge_cnt, "R4 irq edge", edge_cnt, edge_cnt);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_wait(int v);
    wait_wr = 1'b1; wait_wdata = 8'(v);
    @(negedge clk);
    wait_wr = 1'b0;
  endtask

  task automatic select_proto(int c);
    proto_wr = 1'b1; proto_code = 2'(c);
    @(negedge clk);
    proto_wr = 1'b0;
  endtask

  task automatic pulse_eof(output int e);
    e = edge_cnt + 1;
    tx_eof = 1'b1;
    @(negedge clk);
    tx_eof = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
  endtask

  task automatic pulse_fifo();
    fifo_reset = 1'b1; @(negedge clk); fifo_reset = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  // Driver: one full exchange that times out
  task automatic timed_exchange(int w);
    int e;
    pulse_eof(e);
    exp_q.push_back(e + w * DIV);
    idle(w * DIV + 3);
  endtask

  initial begin
    int e, e2;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(wait_value == 8'd14, "R1 wait_value", wait_value, 14);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(noresp_flag == 1'b0, "R1 flag", noresp_flag, 0);

    // R4 default window, R5 flag set and held
    timed_exchange(14);
    check(noresp_flag == 1'b1, "R5 flag set", noresp_flag, 1);
    idle(10);
    check(noresp_flag == 1'b1, "R5 flag held", noresp_flag, 1);
    pulse_clr();
    check(noresp_flag == 1'b0, "R5 flag cleared", noresp_flag, 0);

    // R2 writes, zero mapped to one
    write_wait(3);
    check(wait_value == 8'd3, "R2 write 3", wait_value, 3);
    timed_exchange(3);
    write_wait(0);
    check(wait_value == 8'(eff_wait(0)), "R2 zero becomes one", wait_value, 1);
    timed_exchange(eff_wait(0));
    write_wait(255);
    check(wait_value == 8'd255, "R2 write 255", wait_value, 255);
    timed_exchange(255);

    // R3 presets and priority over a direct write
    for (int c = 0; c < 4; c++) begin
      write_wait(77);
      select_proto(c);
      check(wait_value == 8'(preset_of(c)), "R3 preset", wait_value, preset_of(c));
    end
    wait_wr = 1'b1; wait_wdata = 8'd99; proto_wr = 1'b1; proto_code = 2'b01;
    @(negedge clk);
    wait_wr = 1'b0; proto_wr = 1'b0;
    check(wait_value == 8'd20, "R3 preset wins", wait_value, 20);
    timed_exchange(20);
    pulse_clr();

    // R6 reply mid-window
    write_wait(2);
    pulse_eof(e);
    idle(10);
    pulse_rx();
    idle(2 * DIV + 4);
    check(noresp_flag == 1'b0, "R6 no flag after reply", noresp_flag, 0);

    // R6 reply on the expiry edge
    pulse_eof(e);
    idle(2 * DIV - 1);
    check(edge_cnt + 1 == e + 2 * DIV, "R6 race alignment", edge_cnt + 1, e + 2 * DIV);
    pulse_rx();
    idle(4);
    check(noresp_flag == 1'b0, "R6 reply wins race", noresp_flag, 0);

    // R7 FIFO reset while running and while idle
    pulse_eof(e);
    idle(5);
    pulse_fifo();
    idle(2 * DIV + 4);
    check(noresp_flag == 1'b0, "R7 cancel while running", noresp_flag, 0);
    pulse_fifo();
    idle(3);
    check(noresp_flag == 1'b0 && wait_value == 8'd2, "R7 idle no effect", wait_value, 2);
    timed_exchange(2);
    pulse_clr();

    // R8 restart mid-window
    write_wait(4);
    pulse_eof(e);
    idle(20);
    pulse_eof(e2);
    exp_q.push_back(e2 + 4 * DIV);
    idle(4 * DIV + 3);

    // R8 restart on the expiry edge
    write_wait(1);
    pulse_eof(e);
    idle(DIV - 1);
    pulse_eof(e2);
    check(e2 == e + DIV, "R8 restart alignment", e2, e + DIV);
    exp_q.push_back(e2 + DIV);
    idle(DIV + 3);
    pulse_clr();

    // R4 register change after eof leaves the running exchange alone
    write_wait(3);
    pulse_eof(e);
    exp_q.push_back(e + 3 * DIV);
    idle(5);
    select_proto(2);
    idle(3 * DIV);
    check(wait_value == 8'd48, "R4 register updated", wait_value, 48);
    pulse_clr();

    // R5 set wins over same-edge clear
    write_wait(1);
    pulse_eof(e);
    exp_q.push_back(e + DIV);
    idle(DIV - 1);
    pulse_clr();
    idle(2);
    check(noresp_flag == 1'b1, "R5 set beats clear", noresp_flag, 1);

    idle(5);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule